// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block takes a small microcontroller core into one of four sleep modes and brings it back out. A one-cycle sleep request carries a 2-bit mode select and a flag that says whether an external crystal clock source is configured. While the core sleeps, the block drives enables for the CPU, flash, I/O and ADC clock domains, for the main oscillator and for the general digital input buffers. It decides from the chosen mode which wake sources may end the sleep. When the wake-up sequence finishes, it raises a one-cycle resume pulse.

The deep modes are Power-down and Standby. In these modes a level-triggered external interrupt or a pin change must be seen on two successive samples of a slow, always-on oscillator. That oscillator reaches the block as a one-cycle `slow_tick` pulse, synchronous to `clk`. After Power-down the block waits a set number of slow ticks for the oscillator to start. Standby keeps the oscillator running, so the wait is a short fixed count of main-clock cycles. If the wake condition has gone by the time of the resume pulse, the core still wakes, but the interrupt is not flagged for execution.

The block runs on an always-on clock. The pins used for wake detection have their own buffers, which this block does not gate.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: After reset the block is awake. All five clock enables and `inbuf_en` read 1, and `resume` and `wake_keep` read 0.
- R2: Mode select 2'b00 (Idle) turns off `clk_cpu_en` and `clk_flash_en` and keeps `clk_io_en`, `clk_adc_en` and `osc_en` on.
- R3: Mode select 2'b01 (ADC noise reduction) keeps only `clk_adc_en` and `osc_en` on.
- R4: Mode select 2'b10 (Power-down) turns off all four domain enables and `osc_en`. Mode select 2'b11 with `xtal_sel`=0 does the same.
- R5: Mode select 2'b11 with `xtal_sel`=1 (Standby) turns off all four domain enables and keeps `osc_en` on.
- R6: `inbuf_en` is 0 exactly when both `clk_io_en` and `clk_adc_en` are 0.
- R7: The bits of `wake_src` are: 0 level interrupt, 1 pin change, 2 serial start condition, 3 EEPROM ready, 4 ADC complete and 5 other I/O. Idle accepts all six bits. ADC noise reduction accepts bits 0 to 4. The deep modes accept bits 0 to 2. A source a mode does not accept leaves the enables unchanged and raises no resume.
- R8: In a deep mode, bits 0 and 1 wake the core only when their OR is high on two consecutive `slow_tick` samples. If the level is seen on only one sample, it is dropped.
- R9: The two-sample qualifier is cleared at the sleep request. A level qualified before sleep therefore cannot end the sleep before two new samples.
- R10: In Standby, `resume` rises STBY_CYC+1 clock edges after the edge that completes a wake. Until then only `osc_en` is on.
- R11: In Power-down, `osc_en` turns on in the cycle after the wake is accepted. The domains stay off until STARTUP_TICKS further `slow_tick` pulses have been counted. `resume` is high after the edge of the last of these pulses.
- R12: `resume` is a one-cycle pulse. During it all enables are on. During it `wake_keep` shows whether any source the mode accepts is still high, and the block is awake in the next cycle.
- R13: A sleep request while the block is not awake is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| mode_sel | input | 2 | Sleep mode select |
| xtal_sel | input | 1 | External crystal clock source configured |
| slow_tick | input | 1 | One pulse per slow oscillator period |
| wake_src | input | 6 | Raw wake sources (bit map in R7) |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_flash_en | output | 1 | Flash clock enable |
| clk_io_en | output | 1 | I/O clock enable |
| clk_adc_en | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| inbuf_en | output | 1 | General digital input buffer enable |
| resume | output | 1 | Wake-up complete pulse |
| wake_keep | output | 1 | Wake interrupt still valid at resume |

## Verification
Each mode is entered in turn, and the six enables are compared with the mode's expected pattern. Then every source is driven. In each mode the sources it rejects are raised first, to show they neither wake the core nor move an enable. An accepted source is raised next, to show the wake path and `wake_keep`. The slow-clock patterns cover a level held over two ticks, a level seen on one tick only, and a level qualified before sleep. Together they separate a working two-sample qualifier from a one-sample qualifier and from one that keeps stale samples. In Standby and Power-down, the resume edge is counted against the expected number of cycles and ticks. A source dropped during start-up shows that `wake_keep` follows the live condition and not the one that caused the wake.

// File: rtl/sgc_pkg.sv
// Shared types for the sleep-mode clock-gating controller.
// Assumes mode select 2'b11 means Standby only with a crystal source configured.
package sgc_pkg;

    localparam int NSRC   = 6;
    localparam int W_LVL  = 0;
    localparam int W_PIN  = 1;
    localparam int W_SER  = 2;
    localparam int W_EE   = 3;
    localparam int W_ADC  = 4;
    localparam int W_IO   = 5;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_ADCNR = 2'd1,
        M_PDOWN = 2'd2,
        M_STBY  = 2'd3
    } sleep_mode_e;

    typedef enum logic [2:0] {
        S_AWAKE   = 3'd0,
        S_SLEEP   = 3'd1,
        S_STARTUP = 3'd2,
        S_RESYNC  = 3'd3,
        S_RESUME  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic osc;
    } clk_en_t;

    // Map the raw select and crystal flag onto a sleep mode
    function automatic sleep_mode_e decode_mode(input logic [1:0] sel, input logic xtal);
        case (sel)
            2'b00:   return M_IDLE;
            2'b01:   return M_ADCNR;
            2'b10:   return M_PDOWN;
            default: return xtal ? M_STBY : M_PDOWN;
        endcase
    endfunction

endpackage

// File: rtl/sgc_domain_map.sv
// Per-mode clock domain enables and wake-source mask.
// Assumes gated is high only while the core sleeps or waits to resume, and
// osc_restart is high only during the oscillator start-up wait after Power-down.
module sgc_domain_map
    import sgc_pkg::*;
(
    input  sleep_mode_e     mode,
    input  logic            gated,
    input  logic            osc_restart,
    output clk_en_t         en,
    output logic [NSRC-1:0] wake_mask,
    output logic            deep
);

    // Choose running domains for the current sleep phase
    always_comb begin
        en = '1;
        if (gated) begin
            case (mode)
                M_IDLE:  en = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
                M_ADCNR: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
                M_PDOWN: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: osc_restart};
                default: en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
            endcase
        end
    end

    // Choose accepted wake sources for the latched mode
    always_comb begin
        wake_mask = '0;
        wake_mask[W_LVL] = 1'b1;
        wake_mask[W_PIN] = 1'b1;
        wake_mask[W_SER] = 1'b1;
        if (mode == M_IDLE || mode == M_ADCNR) begin
            wake_mask[W_EE]  = 1'b1;
            wake_mask[W_ADC] = 1'b1;
        end
        if (mode == M_IDLE) begin
            wake_mask[W_IO] = 1'b1;
        end
    end

    assign deep = (mode == M_PDOWN) || (mode == M_STBY);

endmodule

// File: rtl/sgc_level_qual.sv
// Two-sample qualifier for a level wake-up, sampled on slow oscillator ticks.
// Assumes tick is a one-cycle pulse synchronous to clk; clr wins over tick.
module sgc_level_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic lvl,
    output logic qual
);

    logic samp_a;
    logic samp_b;

    // Shift the level through two slow-tick samples, flushed on sleep entry
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            samp_a <= 1'b0;
            samp_b <= 1'b0;
        end else if (tick) begin
            samp_a <= lvl;
            samp_b <= samp_a;
        end
    end

    assign qual = samp_a & samp_b;

    assert_two_samples_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> ($past(tick) && $past(lvl)));

    assert_clear_on_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !qual);

endmodule

// File: rtl/sgc_wake_seq.sv
// Sleep/wake sequencer: latches the mode, waits for a wake, then counts either
// oscillator start-up ticks (Power-down) or main-clock cycles (Standby).
// Assumes wake is already masked and qualified for the latched mode.
module sgc_wake_seq
    import sgc_pkg::*;
#(
    parameter int STBY_CYC      = 6,
    parameter int STARTUP_TICKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_req,
    input  sleep_mode_e mode_in,
    input  logic        tick,
    input  logic        wake,
    output sleep_mode_e mode_q,
    output seq_state_e  state,
    output logic        entry,
    output logic        resume
);

    localparam int CMAX  = (STBY_CYC > STARTUP_TICKS) ? STBY_CYC : STARTUP_TICKS;
    localparam int CNT_W = $clog2(CMAX + 1);

    logic [CNT_W-1:0] cnt;

    // Advance the sleep sequence and its wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_AWAKE;
            mode_q <= M_IDLE;
            cnt    <= '0;
        end else begin
            case (state)
                S_AWAKE: if (sleep_req) begin
                    mode_q <= mode_in;
                    state  <= S_SLEEP;
                end
                S_SLEEP: if (wake) begin
                    cnt <= '0;
                    case (mode_q)
                        M_PDOWN: state <= S_STARTUP;
                        M_STBY:  state <= S_RESYNC;
                        default: state <= S_RESUME;
                    endcase
                end
                S_STARTUP: if (tick) begin
                    if (cnt == CNT_W'(STARTUP_TICKS - 1)) state <= S_RESUME;
                    else                                  cnt   <= cnt + 1'b1;
                end
                S_RESYNC: begin
                    if (cnt == CNT_W'(STBY_CYC - 1)) state <= S_RESUME;
                    else                             cnt   <= cnt + 1'b1;
                end
                default: state <= S_AWAKE;
            endcase
        end
    end

    assign entry  = (state == S_AWAKE) && sleep_req;
    assign resume = (state == S_RESUME);

    assert_resume_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> (!resume && state == S_AWAKE));

    assert_stby_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RESUME && $past(state) == S_RESYNC) |-> ($past(cnt) == CNT_W'(STBY_CYC - 1)));

    assert_req_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLEEP && sleep_req && !wake) |=> (state == S_SLEEP && $stable(mode_q)));

endmodule

// File: rtl/sleep_gate_ctrl.sv
// Top of the sleep-mode clock-gating controller. Decodes the request,
// qualifies deep-mode level wake-ups, masks wake sources per mode and drives
// domain, oscillator and input-buffer enables.
// Assumes clk is always on and slow_tick marks slow oscillator periods.
module sleep_gate_ctrl
    import sgc_pkg::*;
#(
    parameter int STBY_CYC      = 6,
    parameter int STARTUP_TICKS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic [1:0]      mode_sel,
    input  logic            xtal_sel,
    input  logic            slow_tick,
    input  logic [NSRC-1:0] wake_src,
    output logic            clk_cpu_en,
    output logic            clk_flash_en,
    output logic            clk_io_en,
    output logic            clk_adc_en,
    output logic            osc_en,
    output logic            inbuf_en,
    output logic            resume,
    output logic            wake_keep
);

    sleep_mode_e     mode_q;
    seq_state_e      state;
    logic            entry;
    logic            qual;
    logic            wake;
    logic            gated;
    logic            deep;
    clk_en_t         en;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] live;

    sgc_wake_seq #(
        .STBY_CYC      (STBY_CYC),
        .STARTUP_TICKS (STARTUP_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .mode_in   (decode_mode(mode_sel, xtal_sel)),
        .tick      (slow_tick),
        .wake      (wake),
        .mode_q    (mode_q),
        .state     (state),
        .entry     (entry),
        .resume    (resume)
    );

    sgc_level_qual u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (entry),
        .tick  (slow_tick),
        .lvl   (wake_src[W_LVL] | wake_src[W_PIN]),
        .qual  (qual)
    );

    assign gated = (state == S_SLEEP) || (state == S_STARTUP) || (state == S_RESYNC);

    sgc_domain_map u_map (
        .mode        (mode_q),
        .gated       (gated),
        .osc_restart (state == S_STARTUP),
        .en          (en),
        .wake_mask   (mask),
        .deep        (deep)
    );

    assign live = wake_src & mask;

    // Combine accepted sources into a wake, qualifying levels in deep modes
    always_comb begin
        if (deep) wake = qual | live[W_SER];
        else      wake = |live;
    end

    assign clk_cpu_en   = en.cpu;
    assign clk_flash_en = en.flash;
    assign clk_io_en    = en.io;
    assign clk_adc_en   = en.adc;
    assign osc_en       = en.osc;
    assign inbuf_en     = en.io | en.adc;
    assign wake_keep    = resume & (|live);

    assert_gated_cpu_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gated |-> (!clk_cpu_en && !clk_flash_en));

    assert_pd_osc_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLEEP && mode_q == M_PDOWN) |-> !osc_en);

    assert_resume_all_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> (clk_cpu_en && clk_flash_en && clk_io_en && clk_adc_en && osc_en));

endmodule

// File: tb/sleep_gate_ctrl_test.sv
module sleep_gate_ctrl_test;

    localparam int STBY_CYC      = 6;
    localparam int STARTUP_TICKS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       xtal_sel = 1'b0;
    logic       slow_tick = 1'b0;
    logic [5:0] wake_src = '0;
    logic       clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, osc_en, inbuf_en;
    logic       resume, wake_keep;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    sleep_gate_ctrl #(.STBY_CYC(STBY_CYC), .STARTUP_TICKS(STARTUP_TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_sel(mode_sel),
        .xtal_sel(xtal_sel), .slow_tick(slow_tick), .wake_src(wake_src),
        .clk_cpu_en(clk_cpu_en), .clk_flash_en(clk_flash_en), .clk_io_en(clk_io_en),
        .clk_adc_en(clk_adc_en), .osc_en(osc_en), .inbuf_en(inbuf_en),
        .resume(resume), .wake_keep(wake_keep)
    );

    // enables packed as {cpu, flash, io, adc, osc, inbuf}
    function automatic logic [5:0] ens();
        return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, osc_en, inbuf_en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) slow_tick = 1'b1;
        @(negedge clk) slow_tick = 1'b0;
    endtask

    task automatic enter(input logic [1:0] m, input logic x);
        @(negedge clk);
        mode_sel = m; xtal_sel = x; sleep_req = 1'b1;
        @(negedge clk) sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 enables", 32'(ens()), 32'h3f);
        check("R1 resume", 32'(resume), 0);
        check("R1 keep", 32'(wake_keep), 0);
    endtask

    task automatic t_idle();
        enter(2'b00, 1'b0);
        check("R2 idle enables", 32'(ens()), 32'b001111);
        check("R6 inbuf on with io", 32'(inbuf_en), 1);
        wake_src[5] = 1'b1;
        step();
        check("R7 idle io wake resume", 32'(resume), 1);
        check("R12 keep", 32'(wake_keep), 1);
        check("R12 all on", 32'(ens()), 32'h3f);
        wake_src[5] = 1'b0;
        step();
        check("R12 one cycle", 32'(resume), 0);
        check("R12 awake", 32'(ens()), 32'h3f);
    endtask

    task automatic t_adcnr();
        enter(2'b01, 1'b0);
        check("R3 adcnr enables", 32'(ens()), 32'b000111);
        wake_src[5] = 1'b1;
        repeat (3) step();
        check("R7 adcnr ignores io resume", 32'(resume), 0);
        check("R7 adcnr ignores io enables", 32'(ens()), 32'b000111);
        wake_src[5] = 1'b0;
        enter(2'b00, 1'b0);
        step();
        check("R13 request ignored", 32'(ens()), 32'b000111);
        wake_src[4] = 1'b1;
        step();
        check("R7 adcnr adc wake", 32'(resume), 1);
        check("R12 keep adc", 32'(wake_keep), 1);
        wake_src[4] = 1'b0;
        step();
    endtask

    task automatic t_pdown_drop();
        int n;
        enter(2'b10, 1'b0);
        check("R4 pdown enables", 32'(ens()), 0);
        check("R6 inbuf off", 32'(inbuf_en), 0);
        wake_src[3] = 1'b1; wake_src[4] = 1'b1; wake_src[5] = 1'b1;
        repeat (3) step();
        check("R7 pdown ignores ee/adc/io", 32'(resume), 0);
        check("R7 pdown enables kept", 32'(ens()), 0);
        wake_src[5:3] = '0;
        wake_src[0] = 1'b1;
        tick();
        wake_src[0] = 1'b0;
        tick();
        tick();
        repeat (2) step();
        check("R8 single sample dropped", 32'(resume), 0);
        check("R8 osc still off", 32'(osc_en), 0);
        @(negedge clk) wake_src[2] = 1'b1;
        step();
        wake_src[2] = 1'b0;
        check("R11 osc on in start-up", 32'(ens()), 32'b000010);
        n = 0;
        for (int k = 0; k < STARTUP_TICKS; k++) begin
            tick();
            if (resume) break;
            n++;
        end
        check("R11 ticks before resume", 32'(n), STARTUP_TICKS - 1);
        check("R11 resume after last tick", 32'(resume), 1);
        check("R12 dropped source not kept", 32'(wake_keep), 0);
        step();
    endtask

    task automatic t_11_noxtal();
        enter(2'b11, 1'b0);
        check("R4 11 without crystal", 32'(ens()), 0);
        @(negedge clk) wake_src[2] = 1'b1;
        step();
        wake_src[2] = 1'b0;
        check("R4 11 without crystal starts oscillator", 32'(ens()), 32'b000010);
        repeat (STARTUP_TICKS) tick();
        check("R11 resume 11 no crystal", 32'(resume), 1);
        step();
    endtask

    task automatic t_stby();
        int n;
        enter(2'b11, 1'b1);
        check("R5 standby enables", 32'(ens()), 32'b000010);
        wake_src[1] = 1'b1;
        tick();
        tick();
        n = 0;
        for (int k = 0; k < 20; k++) begin
            step();
            n++;
            if (resume) break;
            if (ens() != 6'b000010) check("R10 domains off in wait", 32'(ens()), 32'b000010);
        end
        check("R10 standby resume edge count", 32'(n), STBY_CYC + 1);
        check("R12 pin still high kept", 32'(wake_keep), 1);
        wake_src[1] = 1'b0;
        step();
    endtask

    task automatic t_entry_clear();
        wake_src[0] = 1'b1;
        tick();
        tick();
        enter(2'b10, 1'b0);
        repeat (4) step();
        check("R9 stale level no wake", 32'(resume), 0);
        check("R9 stale level enables", 32'(ens()), 0);
        tick();
        tick();
        step();
        check("R8 two samples wake", 32'(osc_en), 1);
        repeat (STARTUP_TICKS) tick();
        check("R11 resume", 32'(resume), 1);
        check("R12 level kept", 32'(wake_keep), 1);
        wake_src[0] = 1'b0;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_adcnr();
        t_pdown_drop();
        t_11_noxtal();
        t_stby();
        t_entry_clear();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule